// File: doc/BRIEF.md
# Masked Logical Channel Combiner

This block reduces sixteen binary hit lines from a detector front end to a smaller set of logical channels. Each input line can be individually suppressed by a mask bit. The surviving lines are merged by OR over groups of consecutive indices, and the group size can be chosen at run time as two, four or eight. Logical outputs that the chosen group size leaves unused are held at zero. The result is registered, so a logical channel follows its inputs with one clock of latency.

For checking the combining path without real hits, a test mode replaces the sixteen input lines with a programmable 16-bit word held in a register. The mask, the mode and the test word are all held in registers that are written and read through a small synchronous address/data port.

Top module: `lch_combiner`

## Requirements
- R1: After reset the mask, control and pattern registers read as zero (group mode OR2, test mode off) and all logical outputs are low.
- R2: A mask bit set to 1 removes the input of the same index from every logical output. With all sixteen mask bits set, every output is low.
- R3: In mode code 0 (OR2), logical output i is the OR of masked inputs 2i and 2i+1, for i from 0 to 7, and is visible on the clock edge after the one that captured the inputs.
- R4: In mode code 1 (OR4), logical output i for i from 0 to 3 is the OR of masked inputs 4i to 4i+3. Outputs 4 to 7 are low.
- R5: In mode code 2 (OR8), output 0 is the OR of masked inputs 0 to 7 and output 1 the OR of masked inputs 8 to 15. Outputs 2 to 7 are low.
- R6: Mode code 3 is reserved and drives all logical outputs low.
- R7: With the test bit set, the pattern register takes the place of the sixteen input lines, the input port then has no effect, and the mask still applies.
- R8: Register map: address 0 is the mask (bit n masks input n); address 1 is control, with bits 1:0 the mode code and bit 2 the test bit, and upper bits read as zero; address 2 is the test pattern (bit n replaces input n). A write takes effect on the clock edge where the write enable is sampled high. Reads are combinational on the current address. Address 3 reads zero, and writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_in | input | 16 | Physical hit lines |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_addr |
| lch_out | output | 8 | Registered logical channels |

## Verification
A corrupted mask or pattern register shows up on the read port at once. On the logical outputs it appears in the cycle after the first input pattern that hits the affected bit. A wrong mode code shows up within one cycle as a wrong group boundary or as an unused output that is not held at zero. A wrong source select shows as outputs that follow the input port while test mode is set, or that ignore it while test mode is clear. These faults show on the first hit pattern that tells the pattern word apart from the input port. The random phase therefore keeps inputs sparse, so that single bits map to single outputs and a wrong mapping is not hidden by neighbouring hits.

// File: rtl/lch_pkg.sv
package lch_pkg;

   typedef enum logic [1:0] {
      GRP_OR2  = 2'd0,
      GRP_OR4  = 2'd1,
      GRP_OR8  = 2'd2,
      GRP_NONE = 2'd3
   } grp_mode_e;

   localparam int unsigned REG_MASK = 0;
   localparam int unsigned REG_CTRL = 1;
   localparam int unsigned REG_PAT  = 2;

   localparam int unsigned CTRL_MODE_LSB = 0;
   localparam int unsigned CTRL_TEST_BIT = 2;

endpackage

// File: rtl/lch_cfg_regs.sv
module lch_cfg_regs
   import lch_pkg::*;
#(
   parameter int unsigned N_IN   = 16,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [N_IN-1:0]   wdata,
   output logic [N_IN-1:0]   rdata,
   output logic [N_IN-1:0]   mask_q,
   output grp_mode_e         mode_q,
   output logic              test_q,
   output logic [N_IN-1:0]   pattern_q
);

   localparam int unsigned CTRL_W = CTRL_TEST_BIT + 1;

   if (N_IN < CTRL_W) begin : g_bad_width
      $error("lch_cfg_regs: N_IN too narrow for control field");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("lch_cfg_regs: ADDR_W must be at least 2");
   end

   logic sel_mask, sel_ctrl, sel_pat;

   always_comb begin
      sel_mask = (addr == ADDR_W'(REG_MASK));
      sel_ctrl = (addr == ADDR_W'(REG_CTRL));
      sel_pat  = (addr == ADDR_W'(REG_PAT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         mode_q    <= GRP_OR2;
         test_q    <= 1'b0;
         pattern_q <= '0;
      end else if (wr_en) begin
         if (sel_mask) mask_q <= wdata;
         if (sel_ctrl) begin
            mode_q <= grp_mode_e'(wdata[CTRL_MODE_LSB +: 2]);
            test_q <= wdata[CTRL_TEST_BIT];
         end
         if (sel_pat) pattern_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (sel_mask) rdata = mask_q;
      if (sel_ctrl) begin
         rdata[CTRL_MODE_LSB +: 2] = mode_q;
         rdata[CTRL_TEST_BIT]      = test_q;
      end
      if (sel_pat) rdata = pattern_q;
   end

endmodule

// File: rtl/lch_src_sel.sv
module lch_src_sel #(
   parameter int unsigned N_IN = 16
) (
   input  logic [N_IN-1:0] ph_in,
   input  logic [N_IN-1:0] pattern,
   input  logic [N_IN-1:0] mask,
   input  logic            test_en,
   output logic [N_IN-1:0] eff
);

   logic [N_IN-1:0] raw;

   always_comb begin
      raw = test_en ? pattern : ph_in;
   end

   for (genvar n = 0; n < N_IN; n++) begin : g_bit
      assign eff[n] = raw[n] & ~mask[n];
   end

endmodule

// File: rtl/lch_or_tree.sv
module lch_or_tree
   import lch_pkg::*;
#(
   parameter int unsigned N_IN = 16
) (
   input  logic [N_IN-1:0]   eff,
   input  grp_mode_e         mode,
   output logic [N_IN/2-1:0] lch_d
);

   localparam int unsigned N_OUT = N_IN / 2;
   localparam int unsigned N_G4  = N_IN / 4;
   localparam int unsigned N_G8  = N_IN / 8;

   if ((N_IN % 8) != 0 || N_IN == 0) begin : g_bad_n
      $error("lch_or_tree: N_IN must be a nonzero multiple of 8");
   end

   logic [N_OUT-1:0] or2_v;
   logic [N_G4-1:0]  or4_v;
   logic [N_G8-1:0]  or8_v;

   for (genvar i = 0; i < N_OUT; i++) begin : g_or2
      assign or2_v[i] = |eff[2*i +: 2];
   end

   for (genvar i = 0; i < N_G4; i++) begin : g_or4
      assign or4_v[i] = |or2_v[2*i +: 2];
   end

   for (genvar i = 0; i < N_G8; i++) begin : g_or8
      assign or8_v[i] = |or4_v[2*i +: 2];
   end

   always_comb begin
      lch_d = '0;
      unique case (mode)
         GRP_OR2: lch_d = or2_v;
         GRP_OR4: lch_d[N_G4-1:0] = or4_v;
         GRP_OR8: lch_d[N_G8-1:0] = or8_v;
         default: lch_d = '0;
      endcase
   end

endmodule

// File: rtl/lch_combiner.sv
module lch_combiner
   import lch_pkg::*;
#(
   parameter int unsigned N_IN   = 16,
   parameter int unsigned ADDR_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_IN-1:0]     ph_in,
   input  logic                cfg_wr_en,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic [N_IN-1:0]     cfg_wdata,
   output logic [N_IN-1:0]     cfg_rdata,
   output logic [N_IN/2-1:0]   lch_out
);

   localparam int unsigned N_OUT = N_IN / 2;

   logic [N_IN-1:0]  mask_q;
   logic [N_IN-1:0]  pattern_q;
   grp_mode_e        mode_q;
   logic             test_q;
   logic [N_IN-1:0]  src_eff;
   logic [N_OUT-1:0] lch_d;

   lch_cfg_regs #(.N_IN(N_IN), .ADDR_W(ADDR_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr_en),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .rdata     (cfg_rdata),
      .mask_q    (mask_q),
      .mode_q    (mode_q),
      .test_q    (test_q),
      .pattern_q (pattern_q)
   );

   lch_src_sel #(.N_IN(N_IN)) i_src (
      .ph_in   (ph_in),
      .pattern (pattern_q),
      .mask    (mask_q),
      .test_en (test_q),
      .eff     (src_eff)
   );

   lch_or_tree #(.N_IN(N_IN)) i_tree (
      .eff   (src_eff),
      .mode  (mode_q),
      .lch_d (lch_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lch_out <= '0;
      else        lch_out <= lch_d;
   end

endmodule

// File: rtl/lch_combiner_chk.sv
module lch_combiner_chk
   import lch_pkg::*;
#(
   parameter int unsigned N_IN   = 16,
   parameter int unsigned ADDR_W = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [N_IN-1:0]     ph_in,
   input logic                cfg_wr_en,
   input logic [ADDR_W-1:0]   cfg_addr,
   input logic [N_IN-1:0]     cfg_wdata,
   input logic [N_IN-1:0]     cfg_rdata,
   input logic [N_IN/2-1:0]   lch_out,
   input logic [N_IN-1:0]     mask_q,
   input logic [N_IN-1:0]     pattern_q,
   input grp_mode_e           mode_q,
   input logic                test_q
);

   localparam int unsigned N_OUT = N_IN / 2;

   logic [N_IN-1:0] port_src;
   assign port_src = ph_in & ~mask_q;

   p_or2_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode_q == GRP_OR2) && !$past(test_q))
      |-> (lch_out[0] == $past(|port_src[1:0])))
      else $error("R3: OR2 output 0 mismatch");

   p_or4_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode_q == GRP_OR4))
      |-> (lch_out[N_OUT-1:N_IN/4] == '0))
      else $error("R4: unused OR4 outputs not low");

   p_or8_unused_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode_q == GRP_OR8))
      |-> (lch_out[N_OUT-1:N_IN/8] == '0))
      else $error("R5: unused OR8 outputs not low");

   p_reserved_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode_q == GRP_NONE)) |-> (lch_out == '0))
      else $error("R6: reserved mode output not low");

   p_mask_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(&mask_q)) |-> (lch_out == '0))
      else $error("R2: fully masked output not low");

   p_test_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(test_q) && $past(pattern_q == '0)) |-> (lch_out == '0))
      else $error("R7: zero pattern in test mode gave hits");

   p_mask_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cfg_wr_en) && $past(cfg_addr == ADDR_W'(REG_MASK))
       && cfg_addr == ADDR_W'(REG_MASK))
      |-> (cfg_rdata == $past(cfg_wdata)))
      else $error("R8: mask readback mismatch");

   p_pat_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cfg_wr_en) && $past(cfg_addr == ADDR_W'(REG_PAT))
       && cfg_addr == ADDR_W'(REG_PAT))
      |-> (cfg_rdata == $past(cfg_wdata)))
      else $error("R8: pattern readback mismatch");

endmodule

bind lch_combiner lch_combiner_chk #(.N_IN(N_IN), .ADDR_W(ADDR_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ph_in     (ph_in),
   .cfg_wr_en (cfg_wr_en),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .lch_out   (lch_out),
   .mask_q    (mask_q),
   .pattern_q (pattern_q),
   .mode_q    (mode_q),
   .test_q    (test_q)
);

// File: tb/test_lch_combiner.sv
`timescale 1ns/1ps
module test_lch_combiner;

   localparam int NI = 16;
   localparam int NO = 8;
   localparam real CLK_P = 8.0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NI-1:0] ph_in = '0;
   logic          cfg_wr_en = 1'b0;
   logic [1:0]    cfg_addr = '0;
   logic [NI-1:0] cfg_wdata = '0;
   logic [NI-1:0] cfg_rdata;
   logic [NO-1:0] lch_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [NI-1:0] sh_mask = '0;
   logic [NI-1:0] sh_pat  = '0;
   logic [1:0]    sh_mode = '0;
   logic          sh_test = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   lch_combiner i_lch_combiner (
      .clk       (clk),
      .rst_n     (rst_n),
      .ph_in     (ph_in),
      .cfg_wr_en (cfg_wr_en),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .lch_out   (lch_out)
   );

   function automatic logic [NO-1:0] model(logic [NI-1:0] ph, logic [NI-1:0] msk,
                                           logic [NI-1:0] pat, logic [1:0] mode,
                                           logic tst);
      logic [NI-1:0] s;
      logic [NO-1:0] o;
      s = (tst ? pat : ph) & ~msk;
      o = '0;
      for (int i = 0; i < NO; i++) begin
         case (mode)
            2'd0: o[i] = |s[2*i +: 2];
            2'd1: if (i < NI/4) o[i] = |s[4*i +: 4];
            2'd2: if (i < NI/8) o[i] = |s[8*i +: 8];
            default: o[i] = 1'b0;
         endcase
      end
      return o;
   endfunction

   function automatic string mode_tag(logic [1:0] m);
      case (m)
         2'd0: return "R3";
         2'd1: return "R4";
         2'd2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(string req, logic [NI-1:0] act, logic [NI-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [NI-1:0] d);
      cfg_wr_en = 1'b1;
      cfg_addr  = a;
      cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cfg_wr_en = 1'b0;
      case (a)
         2'd0: sh_mask = d;
         2'd1: begin sh_mode = d[1:0]; sh_test = d[2]; end
         2'd2: sh_pat = d;
         default: ;
      endcase
   endtask

   task automatic rd_chk(string req, logic [1:0] a, logic [NI-1:0] exp);
      cfg_addr = a;
      #1;
      chk(req, cfg_rdata, exp);
   endtask

   task automatic drive_chk(string req, logic [NI-1:0] ph);
      ph_in = ph;
      @(posedge clk);
      @(negedge clk);
      chk(req, {8'h00, lch_out}, {8'h00, model(ph, sh_mask, sh_pat, sh_mode, sh_test)});
   endtask

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1", {8'h00, lch_out}, 16'h0000);
      rd_chk("R1", 2'd0, 16'h0000);
      rd_chk("R1", 2'd1, 16'h0000);
      rd_chk("R1", 2'd2, 16'h0000);

      // R3 OR2 walking single bit
      for (int b = 0; b < NI; b++) drive_chk("R3", 16'(1) << b);
      // R3 latency: output follows a clear input after one edge
      drive_chk("R3", 16'h0000);

      // R2 mask
      wr(2'd0, 16'h00F0);
      rd_chk("R8", 2'd0, 16'h00F0);
      drive_chk("R2", 16'h00F0);
      drive_chk("R2", 16'h01F0);
      wr(2'd0, 16'hFFFF);
      drive_chk("R2", 16'hFFFF);
      wr(2'd0, 16'h0000);

      // R4 OR4
      wr(2'd1, 16'h0001);
      rd_chk("R8", 2'd1, 16'h0001);
      drive_chk("R4", 16'h8000);
      drive_chk("R4", 16'h0120);
      drive_chk("R4", 16'hFFFF);

      // R5 OR8
      wr(2'd1, 16'h0002);
      drive_chk("R5", 16'h0080);
      drive_chk("R5", 16'h0100);
      drive_chk("R5", 16'hFFFF);

      // R6 reserved mode
      wr(2'd1, 16'h0003);
      drive_chk("R6", 16'hFFFF);

      // R7 test pattern, input port ignored, mask applies
      wr(2'd2, 16'h0201);
      wr(2'd1, 16'h0004);
      rd_chk("R8", 2'd1, 16'h0004);
      drive_chk("R7", 16'hFFFF);
      drive_chk("R7", 16'h0000);
      wr(2'd0, 16'h0001);
      drive_chk("R7", 16'hFFFF);

      // R8 unmapped address, upper control bits
      wr(2'd3, 16'hABCD);
      rd_chk("R8", 2'd3, 16'h0000);
      rd_chk("R8", 2'd0, 16'h0001);
      rd_chk("R8", 2'd2, 16'h0201);
      wr(2'd1, 16'hFFF8);
      rd_chk("R8", 2'd1, 16'h0000);
      wr(2'd0, 16'h0000);

      // random phase
      for (int k = 0; k < 400; k++) begin
         if (($urandom % 8) == 0) begin
            int sel;
            sel = $urandom % 3;
            if (sel == 0)      wr(2'd0, 16'($urandom & $urandom & $urandom));
            else if (sel == 1) wr(2'd1, 16'($urandom % 8));
            else               wr(2'd2, 16'($urandom & $urandom));
            rd_chk("R8", 2'(sel), (sel == 1) ? {13'd0, sh_test, sh_mode}
                                             : (sel == 0 ? sh_mask : sh_pat));
         end
         drive_chk(sh_test ? "R7" : mode_tag(sh_mode), 16'($urandom & $urandom & $urandom));
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule